// File: doc/BRIEF.md
# Multi-cycle RV32I control sequencer

This block is the control half of a small, non-pipelined RV32I core. Every instruction walks through a fixed chain of states. In each state the sequencer drives the datapath controls: the ALU operation, the two operand selects, the register and program-counter write strobes, and the requests to the load/store unit. The program counter is one of the datapath registers. Each new PC value is formed by the shared ALU and written back in a dedicated state, so the datapath needs no separate incrementer.

Instructions reach the sequencer over the system bus. The sequencer pulses a fetch request, then waits until the load/store unit reports that the word is ready, and latches the word at that point. Branch outcomes come back from the ALU as a single compare flag. An environment call, or any encoding the core cannot execute, parks the sequencer in a halt state until reset. A user-level interrupt return asks the datapath to reload the PC, stack pointer and frame pointer from their shadow copies.

Top module: `rvseq_ctrl`

## Requirements
- R1: Reset is synchronous and active low. The first state after reset is boot (state code 8). In boot, `pc_we_o` is 1, `opa_sel_o` is 2 (zero), `opb_sel_o` is 1 (immediate), `alu_op_o` is 0 (add) and `imm_o` is the reset vector 0x0000_0074. The next state is fetch.
- R2: State codes are fetch 0, wait-fetch 1, decode 2, execute 3, write 4, update-PC 5, store-PC 6 and halt 7. The normal order is 0,1,2,3,4,5,6,0. `fetch_req_o` is high only in fetch.
- R3: Wait-fetch repeats while `instr_rdy_i` is low. The instruction word is taken from `instr_i` only in the cycle in which `instr_rdy_i` is high.
- R4: In execute and write, the ALU code for register and immediate arithmetic is one of add 0, sub 1, sll 2, slt 3, sltu 4, xor 5, srl 6, sra 7, or 8, and 9. Instruction bit 30 selects sub (register form only) and sra (both forms).
- R5: `imm_o` is the sign-extended immediate of the latched word in the format its opcode implies. The I format applies to arithmetic-immediate, JALR and load. S, B, U and J apply to store, branch, LUI/AUIPC and JAL. Every other opcode gives zero.
- R6: In execute and write, the operand selects (a: 0 rs1, 1 PC, 2 zero; b: 0 rs2, 1 immediate, 2 four) are as follows. Register ops use 0/0, immediate ops 0/1, LUI 2/1 and AUIPC 1/1. JAL/JALR use 1/2 with add, so the link value PC+4 is formed. `rd_we_o` is high in write for arithmetic, LUI, AUIPC, JAL, JALR and load.
- R7: In execute, a branch drives compare codes eq 10, ne 11, lt 12, ge 13, ltu 14, geu 15 with selects 0/0. `alu_cmp_i` is latched at the end of execute. In update-PC and store-PC, b selects the immediate if the branch is taken and four if it is not.
- R8: A load or store holds `ls_req_o` high in execute until `mem_done_i`. `ls_we_o` marks a store. Meanwhile the ALU forms PC+4 (selects 1/2, add). A load writes rd in write with `wb_load_o` high; a store writes no register.
- R9: `pc_we_o` is high in store-PC and in boot only. The JAL target uses selects 1/1. The JALR target uses selects 0/1 with `tgt_align_o` high, which clears bit 0.
- R10: URET (0x0020_0073) raises `restore_o` in store-PC and leaves `pc_we_o` low.
- R11: ECALL (0x0000_0073) moves decode to halt. `halted_o` then stays high, and no fetch request or write strobe is issued until reset.
- R12: An unknown opcode, or a branch with funct3 010 or 011, halts in the same way as ECALL.
- R13: FENCE, EBREAK and CSR instructions write no register and make no memory request. They only advance the PC by four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_i | input | 32 | Instruction word from the load/store unit |
| instr_rdy_i | input | 1 | Instruction word valid |
| mem_done_i | input | 1 | Data load/store finished |
| alu_cmp_i | input | 1 | ALU compare result |
| state_o | output | 4 | Current sequencer state code |
| fetch_req_o | output | 1 | Start instruction fetch |
| imm_o | output | XLEN | Decoded immediate / reset vector |
| alu_op_o | output | 4 | ALU operation code |
| opa_sel_o | output | 2 | ALU operand A select |
| opb_sel_o | output | 2 | ALU operand B select |
| rd_we_o | output | 1 | Destination register write |
| wb_load_o | output | 1 | Write-back takes load data |
| ls_req_o | output | 1 | Data memory request |
| ls_we_o | output | 1 | Data memory request is a store |
| pc_we_o | output | 1 | Program counter write |
| tgt_align_o | output | 1 | Clear bit 0 of the PC being formed |
| restore_o | output | 1 | Reload PC/SP/FP from shadow registers |
| halted_o | output | 1 | Core halted |

## Verification
The hardest cases to reach from the ports are the stalled ones. One is an instruction word that changes while wait-fetch is stalled. Another is a load whose completion lags many cycles, and a third is a reset that lands in the middle of an instruction. The bench answers each fetch after a delay chosen per instruction, and drives the complement of the real word on `instr_i` until the ready cycle, so a capture on the wrong cycle shows up in the decoded immediate or ALU code. The same approach stretches memory completion, and the bench pulls reset while a long load is still pending in execute. It also inverts `alu_cmp_i` outside execute, so that a branch outcome latched in the wrong state is exposed.

// File: rtl/rvseq_pkg.sv
// Shared types for the multi-cycle sequencer: state codes, ALU codes,
// operand selects, instruction classes and opcode values.
package rvseq_pkg;

    typedef enum logic [3:0] {
        ST_FETCH   = 4'd0,
        ST_WAITF   = 4'd1,
        ST_DECODE  = 4'd2,
        ST_EXEC    = 4'd3,
        ST_WRITE   = 4'd4,
        ST_UPDPC   = 4'd5,
        ST_STOREPC = 4'd6,
        ST_HALT    = 4'd7,
        ST_BOOT    = 4'd8
    } state_e;

    typedef enum logic [3:0] {
        ALU_ADD = 4'd0,  ALU_SUB = 4'd1,  ALU_SLL = 4'd2,  ALU_SLT = 4'd3,
        ALU_SLTU = 4'd4, ALU_XOR = 4'd5,  ALU_SRL = 4'd6,  ALU_SRA = 4'd7,
        ALU_OR = 4'd8,   ALU_AND = 4'd9,  ALU_EQ = 4'd10,  ALU_NE = 4'd11,
        ALU_LT = 4'd12,  ALU_GE = 4'd13,  ALU_LTU = 4'd14, ALU_GEU = 4'd15
    } alu_e;

    typedef enum logic [1:0] {A_RS1 = 2'd0, A_PC = 2'd1, A_ZERO = 2'd2} asel_e;
    typedef enum logic [1:0] {B_RS2 = 2'd0, B_IMM = 2'd1, B_FOUR = 2'd2} bsel_e;

    typedef enum logic [3:0] {
        C_OP, C_OPIMM, C_LUI, C_AUIPC, C_JAL, C_JALR,
        C_BR, C_LD, C_ST, C_NOP, C_URET, C_HALT
    } cls_e;

    typedef enum logic [2:0] {F_NONE, F_I, F_S, F_B, F_U, F_J} fmt_e;

    localparam logic [6:0] OPC_OP     = 7'b0110011;
    localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [6:0] OPC_LUI    = 7'b0110111;
    localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_FENCE  = 7'b0001111;
    localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

    localparam logic [24:0] SYS_ECALL = 25'h0000000;
    localparam logic [24:0] SYS_URET  = 25'h0004000;

endpackage

// File: rtl/rvseq_decode.sv
// Instruction decoder. Purely combinational.
// Maps a latched instruction word to its execution class, the ALU code
// used in execute, and the sign-extended immediate.
// Assumes XLEN >= 32.
module rvseq_decode
    import rvseq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:0]     ir,
    output cls_e            cls,
    output alu_e            op,
    output logic [XLEN-1:0] imm
);
    localparam int SEXT = XLEN - 32;

    logic [6:0] opc;
    logic [2:0] f3;
    logic       alt;
    fmt_e       fmt;

    assign opc = ir[6:0];
    assign f3  = ir[14:12];
    assign alt = ir[30];

    // Arithmetic code from funct3, with bit 30 picking sub/sra.
    function automatic alu_e arith(input logic [2:0] f, input logic a, input logic reg_form);
        unique case (f)
            3'd0: arith = (a && reg_form) ? ALU_SUB : ALU_ADD;
            3'd1: arith = ALU_SLL;
            3'd2: arith = ALU_SLT;
            3'd3: arith = ALU_SLTU;
            3'd4: arith = ALU_XOR;
            3'd5: arith = a ? ALU_SRA : ALU_SRL;
            3'd6: arith = ALU_OR;
            default: arith = ALU_AND;
        endcase
    endfunction

    // Class, format and ALU code selection by opcode.
    always_comb begin
        cls = C_HALT;
        fmt = F_NONE;
        op  = ALU_ADD;
        unique case (opc)
            OPC_OP:    begin cls = C_OP;    op = arith(f3, alt, 1'b1); end
            OPC_OPIMM: begin cls = C_OPIMM; fmt = F_I; op = arith(f3, alt, 1'b0); end
            OPC_LUI:   begin cls = C_LUI;   fmt = F_U; end
            OPC_AUIPC: begin cls = C_AUIPC; fmt = F_U; end
            OPC_JAL:   begin cls = C_JAL;   fmt = F_J; end
            OPC_JALR:  begin cls = C_JALR;  fmt = F_I; end
            OPC_LOAD:  begin cls = C_LD;    fmt = F_I; end
            OPC_STORE: begin cls = C_ST;    fmt = F_S; end
            OPC_FENCE: cls = C_NOP;
            OPC_BRANCH: begin
                fmt = F_B;
                cls = C_BR;
                unique case (f3)
                    3'd0: op = ALU_EQ;
                    3'd1: op = ALU_NE;
                    3'd4: op = ALU_LT;
                    3'd5: op = ALU_GE;
                    3'd6: op = ALU_LTU;
                    3'd7: op = ALU_GEU;
                    default: cls = C_HALT;
                endcase
            end
            OPC_SYSTEM: begin
                if (f3 != 3'd0)                cls = C_NOP;
                else if (ir[31:7] == SYS_ECALL) cls = C_HALT;
                else if (ir[31:7] == SYS_URET)  cls = C_URET;
                else                            cls = C_NOP;
            end
            default: cls = C_HALT;
        endcase
    end

    // Immediate assembly per format, sign-extended to XLEN.
    always_comb begin
        unique case (fmt)
            F_I: imm = {{(XLEN-12){ir[31]}}, ir[31:20]};
            F_S: imm = {{(XLEN-12){ir[31]}}, ir[31:25], ir[11:7]};
            F_B: imm = {{(XLEN-13){ir[31]}}, ir[31], ir[7], ir[30:25], ir[11:8], 1'b0};
            F_U: imm = {{SEXT{ir[31]}}, ir[31:12], 12'h000};
            F_J: imm = {{(XLEN-21){ir[31]}}, ir[31], ir[19:12], ir[20], ir[30:21], 1'b0};
            default: imm = '0;
        endcase
    end
endmodule

// File: rtl/rvseq_fsm.sv
// Sequencer state register, instruction register and branch-taken flag.
// Assumes the decoder classifies the instruction register combinationally.
module rvseq_fsm
    import rvseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] instr_i,
    input  logic        instr_rdy_i,
    input  logic        mem_done_i,
    input  logic        alu_cmp_i,
    input  cls_e        cls,
    output state_e      state,
    output logic [31:0] ir,
    output logic        taken
);
    state_e nxt;
    logic   is_mem;

    assign is_mem = (cls == C_LD) || (cls == C_ST);

    // Next-state selection along the fixed instruction chain.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_BOOT:    nxt = ST_FETCH;
            ST_FETCH:   nxt = ST_WAITF;
            ST_WAITF:   nxt = instr_rdy_i ? ST_DECODE : ST_WAITF;
            ST_DECODE:  nxt = (cls == C_HALT) ? ST_HALT : ST_EXEC;
            ST_EXEC:    nxt = (is_mem && !mem_done_i) ? ST_EXEC : ST_WRITE;
            ST_WRITE:   nxt = ST_UPDPC;
            ST_UPDPC:   nxt = ST_STOREPC;
            ST_STOREPC: nxt = ST_FETCH;
            default:    nxt = ST_HALT;
        endcase
    end

    // State, instruction capture and branch outcome registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_BOOT;
            ir    <= '0;
            taken <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_WAITF && instr_rdy_i) ir <= instr_i;
            if (state == ST_EXEC && cls == C_BR)  taken <= alu_cmp_i;
        end
    end

    p_boot_to_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_BOOT |=> state == ST_FETCH);
    p_store_to_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_STOREPC |=> state == ST_FETCH);
    p_wait_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAITF && !instr_rdy_i) |=> (state == ST_WAITF && $stable(ir)));
    p_ir_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAITF && instr_rdy_i) |=> ir == $past(instr_i));
    p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && is_mem && !mem_done_i) |=> state == ST_EXEC);
    p_halt_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_HALT |=> state == ST_HALT);
endmodule

// File: rtl/rvseq_drive.sv
// Control output generation from state, decoded class and branch flag.
// Purely combinational; assumes the PC is formed by the shared ALU.
module rvseq_drive
    import rvseq_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = 32'h0000_0074
) (
    input  state_e          state,
    input  cls_e            cls,
    input  alu_e            dec_op,
    input  logic [XLEN-1:0] dec_imm,
    input  logic            taken,
    output logic [XLEN-1:0] imm,
    output alu_e            op,
    output asel_e           asel,
    output bsel_e           bsel,
    output logic            rd_we,
    output logic            wb_load,
    output logic            ls_req,
    output logic            ls_we,
    output logic            pc_we,
    output logic            align,
    output logic            restore
);
    // Immediate bus carries the reset vector while booting.
    assign imm = (state == ST_BOOT) ? RESET_PC : dec_imm;

    // Per-state strobes and ALU configuration.
    always_comb begin
        op      = ALU_ADD;
        asel    = A_PC;
        bsel    = B_FOUR;
        rd_we   = 1'b0;
        wb_load = 1'b0;
        ls_req  = 1'b0;
        ls_we   = 1'b0;
        pc_we   = 1'b0;
        align   = 1'b0;
        restore = 1'b0;
        unique case (state)
            ST_BOOT: begin
                asel  = A_ZERO;
                bsel  = B_IMM;
                pc_we = 1'b1;
            end
            ST_EXEC, ST_WRITE: begin
                unique case (cls)
                    C_OP:    begin asel = A_RS1;  bsel = B_RS2; op = dec_op; end
                    C_OPIMM: begin asel = A_RS1;  bsel = B_IMM; op = dec_op; end
                    C_BR:    begin asel = A_RS1;  bsel = B_RS2; op = dec_op; end
                    C_LUI:   begin asel = A_ZERO; bsel = B_IMM; end
                    C_AUIPC: begin asel = A_PC;   bsel = B_IMM; end
                    C_LD, C_ST: begin
                        ls_req = (state == ST_EXEC);
                        ls_we  = (state == ST_EXEC) && (cls == C_ST);
                    end
                    default: ;
                endcase
                if (state == ST_WRITE) begin
                    rd_we   = cls inside {C_OP, C_OPIMM, C_LUI, C_AUIPC, C_JAL, C_JALR, C_LD};
                    wb_load = (cls == C_LD);
                end
            end
            ST_UPDPC, ST_STOREPC: begin
                unique case (cls)
                    C_JAL:  bsel = B_IMM;
                    C_JALR: begin asel = A_RS1; bsel = B_IMM; align = 1'b1; end
                    C_BR:   bsel = taken ? B_IMM : B_FOUR;
                    default: ;
                endcase
                restore = (state == ST_STOREPC) && (cls == C_URET);
                pc_we   = (state == ST_STOREPC) && (cls != C_URET);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rvseq_ctrl.sv
// Top of the multi-cycle RV32I sequencer: decoder, state machine and
// output driver. Assumes an external ALU, register file holding the PC,
// and a load/store unit handshaking through instr_rdy_i / mem_done_i.
module rvseq_ctrl #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = 32'h0000_0074
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     instr_i,
    input  logic            instr_rdy_i,
    input  logic            mem_done_i,
    input  logic            alu_cmp_i,
    output logic [3:0]      state_o,
    output logic            fetch_req_o,
    output logic [XLEN-1:0] imm_o,
    output logic [3:0]      alu_op_o,
    output logic [1:0]      opa_sel_o,
    output logic [1:0]      opb_sel_o,
    output logic            rd_we_o,
    output logic            wb_load_o,
    output logic            ls_req_o,
    output logic            ls_we_o,
    output logic            pc_we_o,
    output logic            tgt_align_o,
    output logic            restore_o,
    output logic            halted_o
);
    import rvseq_pkg::*;

    state_e          state;
    logic [31:0]     ir;
    logic            taken;
    cls_e            cls;
    alu_e            dec_op, op;
    asel_e           asel;
    bsel_e           bsel;
    logic [XLEN-1:0] dec_imm;

    rvseq_decode #(.XLEN(XLEN)) u_dec (
        .ir (ir), .cls (cls), .op (dec_op), .imm (dec_imm)
    );

    rvseq_fsm u_fsm (
        .clk (clk), .rst_n (rst_n), .instr_i (instr_i), .instr_rdy_i (instr_rdy_i),
        .mem_done_i (mem_done_i), .alu_cmp_i (alu_cmp_i), .cls (cls),
        .state (state), .ir (ir), .taken (taken)
    );

    rvseq_drive #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_drv (
        .state (state), .cls (cls), .dec_op (dec_op), .dec_imm (dec_imm), .taken (taken),
        .imm (imm_o), .op (op), .asel (asel), .bsel (bsel), .rd_we (rd_we_o),
        .wb_load (wb_load_o), .ls_req (ls_req_o), .ls_we (ls_we_o), .pc_we (pc_we_o),
        .align (tgt_align_o), .restore (restore_o)
    );

    assign state_o     = state;
    assign alu_op_o    = op;
    assign opa_sel_o   = asel;
    assign opb_sel_o   = bsel;
    assign fetch_req_o = (state == ST_FETCH);
    assign halted_o    = (state == ST_HALT);

    p_boot_vector_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 4'd8) |-> (pc_we_o && imm_o == RESET_PC));
    p_ls_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_req_o && !mem_done_i) |=> ls_req_o);
    p_pc_write_states_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we_o |=> (state_o == 4'd0));
    p_restore_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restore_o |-> (!pc_we_o && $past(state_o) == 4'd5));
    p_halt_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |-> !(fetch_req_o || pc_we_o || rd_we_o || ls_req_o));
endmodule

// File: tb/tb_rvseq_ctrl.sv
// Cycle-by-cycle reference model of the sequencer, compared on every clock.
module tb_rvseq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr_i = '0;
    logic        instr_rdy_i = 1'b0, mem_done_i = 1'b0, alu_cmp_i = 1'b0;
    logic [3:0]  state_o, alu_op_o;
    logic [31:0] imm_o;
    logic [1:0]  opa_sel_o, opb_sel_o;
    logic        fetch_req_o, rd_we_o, wb_load_o, ls_req_o, ls_we_o;
    logic        pc_we_o, tgt_align_o, restore_o, halted_o;

    always #10 clk = ~clk;

    rvseq_ctrl dut (.*);

    localparam int K_OP = 0, K_OPI = 1, K_LUI = 2, K_AUI = 3, K_JAL = 4, K_JALR = 5,
                   K_BR = 6, K_LD = 7, K_ST = 8, K_NOP = 9, K_URET = 10, K_HALT = 11;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [31:0] pw[$];
    bit          pcmp[$];
    int          pdel[$];
    string       ptag[$];
    int          pidx = 0;

    int          ms = 8, wcnt = 0;
    bit          mvalid = 0, mtaken = 0, cur_cmp = 0;
    logic [31:0] mir = '0;
    int          cur_del = 0;
    string       cur_tag = "R2";

    task automatic add(logic [31:0] w, bit c, int d, string t);
        pw.push_back(w); pcmp.push_back(c); pdel.push_back(d); ptag.push_back(t);
    endtask

    function automatic logic [31:0] r_t(int f7, int rs2, int rs1, int f3, int rd, int op);
        return {7'(f7), 5'(rs2), 5'(rs1), 3'(f3), 5'(rd), 7'(op)};
    endfunction
    function automatic logic [31:0] i_t(int imm, int rs1, int f3, int rd, int op);
        return {12'(imm), 5'(rs1), 3'(f3), 5'(rd), 7'(op)};
    endfunction
    function automatic logic [31:0] s_t(int imm, int rs2, int rs1, int f3);
        logic [11:0] m = 12'(imm);
        return {m[11:5], 5'(rs2), 5'(rs1), 3'(f3), m[4:0], 7'h23};
    endfunction
    function automatic logic [31:0] b_t(int imm, int rs2, int rs1, int f3);
        logic [12:0] m = 13'(imm);
        return {m[12], m[10:5], 5'(rs2), 5'(rs1), 3'(f3), m[4:1], m[11], 7'h63};
    endfunction
    function automatic logic [31:0] u_t(int v, int rd, int op);
        return {20'(v), 5'(rd), 7'(op)};
    endfunction
    function automatic logic [31:0] j_t(int imm, int rd);
        logic [20:0] m = 21'(imm);
        return {m[20], m[10:1], m[11], m[19:12], 5'(rd), 7'h6F};
    endfunction

    function automatic int mcls(logic [31:0] ir);
        int f3 = int'(ir[14:12]);
        case (int'(ir[6:0]))
            'h33: return K_OP;
            'h13: return K_OPI;
            'h37: return K_LUI;
            'h17: return K_AUI;
            'h6F: return K_JAL;
            'h67: return K_JALR;
            'h63: return (f3 == 2 || f3 == 3) ? K_HALT : K_BR;
            'h03: return K_LD;
            'h23: return K_ST;
            'h0F: return K_NOP;
            'h73: begin
                if (f3 != 0) return K_NOP;
                if (ir == 32'h0000_0073) return K_HALT;
                if (ir == 32'h0020_0073) return K_URET;
                return K_NOP;
            end
            default: return K_HALT;
        endcase
    endfunction

    function automatic int mop(logic [31:0] ir);
        int base[8] = '{0, 2, 3, 4, 5, 6, 8, 9};
        int brc[8]  = '{10, 11, -1, -1, 12, 13, 14, 15};
        int f3 = int'(ir[14:12]);
        int r;
        if (ir[6:0] == 7'h63) return brc[f3];
        if (ir[6:0] != 7'h33 && ir[6:0] != 7'h13) return 0;
        r = base[f3];
        if (f3 == 5 && ir[30]) r = 7;
        if (f3 == 0 && ir[30] && ir[6:0] == 7'h33) r = 1;
        return r;
    endfunction

    function automatic logic [31:0] mimm(logic [31:0] ir);
        case (int'(ir[6:0]))
            'h13, 'h67, 'h03: return 32'($signed(ir[31:20]));
            'h23: return 32'($signed({ir[31:25], ir[11:7]}));
            'h63: return 32'($signed({ir[31], ir[7], ir[30:25], ir[11:8], 1'b0}));
            'h37, 'h17: return {ir[31:12], 12'h000};
            'h6F: return 32'($signed({ir[31], ir[19:12], ir[20], ir[30:21], 1'b0}));
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string tag, string f, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h (state %0d)", tag, f, act, exp, ms);
        end
    endtask

    // Reference model: advances on each rising edge from the driven inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 8; mir = '0; mtaken = 0; wcnt = 0; mvalid = 1;
        end else if (mvalid) begin
            case (ms)
                8: ms = 0;
                0: begin ms = 1; wcnt = 0; end
                1: if (instr_rdy_i) begin
                       mir = instr_i; cur_cmp = pcmp[pidx]; cur_del = pdel[pidx];
                       cur_tag = ptag[pidx]; pidx++; ms = 2;
                   end else wcnt++;
                2: begin ms = (mcls(mir) == K_HALT) ? 7 : 3; wcnt = 0; end
                3: begin
                       if (mcls(mir) == K_BR) mtaken = alu_cmp_i;
                       if (mcls(mir) == K_LD || mcls(mir) == K_ST) begin
                           if (mem_done_i) ms = 4; else wcnt++;
                       end else ms = 4;
                   end
                4: ms = 5;
                5: ms = 6;
                6: ms = 0;
                default: ms = 7;
            endcase
        end
    end

    // Compare at the falling edge, then drive the next inputs.
    always @(negedge clk) begin
        int k, e_op, e_a, e_b;
        bit e_rd, e_wbl, e_lr, e_lw, e_pc, e_al, e_rs, mem;
        string tg;
        if (mvalid) begin
            k = mcls(mir);
            tg = (ms == 8) ? "R1" : (ms == 0) ? "R2" :
                 (ms == 1) ? ((pidx < pw.size()) ? ptag[pidx] : "R2") : cur_tag;
            e_op = 0; e_a = 1; e_b = 2;
            {e_rd, e_wbl, e_lr, e_lw, e_pc, e_al, e_rs} = '0;
            if (ms == 8) begin e_a = 2; e_b = 1; e_pc = 1; end
            if (ms == 3 || ms == 4) begin
                case (k)
                    K_OP, K_BR: begin e_a = 0; e_b = 0; e_op = mop(mir); end
                    K_OPI: begin e_a = 0; e_b = 1; e_op = mop(mir); end
                    K_LUI: begin e_a = 2; e_b = 1; end
                    K_AUI: begin e_a = 1; e_b = 1; end
                    K_LD, K_ST: begin e_lr = (ms == 3); e_lw = (ms == 3 && k == K_ST); end
                    default: ;
                endcase
                if (ms == 4) begin
                    e_rd = (k <= K_JALR) || (k == K_LD);
                    e_wbl = (k == K_LD);
                end
            end
            if (ms == 5 || ms == 6) begin
                if (k == K_JAL) e_b = 1;
                if (k == K_JALR) begin e_a = 0; e_b = 1; e_al = 1; end
                if (k == K_BR) e_b = mtaken ? 1 : 2;
                e_rs = (ms == 6 && k == K_URET);
                e_pc = (ms == 6 && k != K_URET);
            end
            chk(tg, "state", 32'(state_o), 32'(ms));
            chk(tg, "fetch_req", 32'(fetch_req_o), 32'(ms == 0));
            chk(tg, "halted", 32'(halted_o), 32'(ms == 7));
            chk(tg, "imm", imm_o, (ms == 8) ? 32'h74 : mimm(mir));
            chk(tg, "alu_op", 32'(alu_op_o), 32'(e_op));
            chk(tg, "opa", 32'(opa_sel_o), 32'(e_a));
            chk(tg, "opb", 32'(opb_sel_o), 32'(e_b));
            chk(tg, "rd_we", 32'(rd_we_o), 32'(e_rd));
            chk(tg, "wb_load", 32'(wb_load_o), 32'(e_wbl));
            chk(tg, "ls_req", 32'(ls_req_o), 32'(e_lr));
            chk(tg, "ls_we", 32'(ls_we_o), 32'(e_lw));
            chk(tg, "pc_we", 32'(pc_we_o), 32'(e_pc));
            chk(tg, "align", 32'(tgt_align_o), 32'(e_al));
            chk(tg, "restore", 32'(restore_o), 32'(e_rs));
        end
        instr_rdy_i = (ms == 1) && (pidx < pw.size()) && (wcnt >= pdel[pidx]);
        instr_i     = (pidx < pw.size()) ? (instr_rdy_i ? pw[pidx] : ~pw[pidx]) : 32'h0;
        mem = (mcls(mir) == K_LD) || (mcls(mir) == K_ST);
        mem_done_i  = (ms == 3) && mem && (wcnt >= cur_del);
        alu_cmp_i   = (ms == 3) ? cur_cmp : !cur_cmp;
    end

    task automatic wait_state(int s);
        while (ms != s) @(negedge clk);
    endtask

    task automatic restart();
        rst_n = 0;
        pw.delete(); pcmp.delete(); pdel.delete(); ptag.delete(); pidx = 0;
    endtask

    initial begin
        // Program A: every instruction class, variable fetch and memory delays.
        add(r_t(0, 2, 1, 0, 3, 'h33), 0, 0, "R4");        // ADD
        add(r_t('h20, 2, 1, 0, 3, 'h33), 0, 3, "R4");     // SUB
        add(r_t('h20, 2, 1, 5, 3, 'h33), 0, 1, "R4");     // SRA
        add(r_t(0, 2, 1, 3, 3, 'h33), 0, 0, "R4");        // SLTU
        add(i_t(-5, 1, 0, 4, 'h13), 0, 0, "R4");          // ADDI, bit30 set: still add
        add(i_t('h403, 1, 5, 4, 'h13), 0, 2, "R4");       // SRAI
        add(i_t(7, 1, 1, 4, 'h13), 0, 0, "R4");           // SLLI
        add(u_t('hABCDE, 5, 'h37), 0, 0, "R5");           // LUI
        add(u_t('h12345, 5, 'h17), 0, 0, "R6");           // AUIPC
        add(j_t(-12, 1), 0, 0, "R9");                     // JAL
        add(i_t(-3, 5, 0, 1, 'h67), 0, 1, "R9");          // JALR
        add(b_t(-16, 2, 1, 0), 1, 0, "R7");               // BEQ taken
        add(b_t('h7FC, 2, 1, 4), 0, 0, "R7");             // BLT not taken
        add(i_t('h123, 2, 2, 6, 'h03), 0, 4, "R8");       // LW, slow memory
        add(s_t(-4, 6, 2, 2), 0, 0, "R8");                // SW
        add(i_t(0, 0, 0, 0, 'h0F), 0, 0, "R13");          // FENCE
        add(i_t('h300, 1, 1, 2, 'h73), 0, 0, "R13");      // CSRRW
        add(i_t(1, 0, 0, 0, 'h73), 0, 0, "R13");          // EBREAK
        add(i_t(2, 0, 0, 0, 'h73), 0, 0, "R10");          // URET
        add(i_t('h555, 3, 0, 3, 'h13), 0, 9, "R3");       // long fetch stall
        add(32'h0000_0073, 0, 0, "R11");                  // ECALL
        repeat (3) @(negedge clk);
        rst_n = 1;
        wait_state(7);
        repeat (20) @(negedge clk);                       // R11: halt is sticky

        // Program D: reset while a load waits on memory (R1).
        restart();
        add(i_t(8, 1, 2, 2, 'h03), 0, 20, "R8");
        repeat (2) @(negedge clk);
        rst_n = 1;
        wait_state(3);
        repeat (3) @(negedge clk);

        // Program B: unknown opcode halts (R12).
        restart();
        add(i_t(1, 1, 0, 1, 'h13), 0, 0, "R4");
        add(32'h0000_007F, 0, 0, "R12");
        repeat (2) @(negedge clk);
        rst_n = 1;
        wait_state(7);
        repeat (6) @(negedge clk);

        // Program C: branch with reserved funct3 halts (R12).
        restart();
        add(b_t(8, 2, 1, 2), 1, 1, "R12");
        repeat (2) @(negedge clk);
        rst_n = 1;
        wait_state(7);
        repeat (6) @(negedge clk);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R2 watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule